// File: doc/BRIEF.md
# Configurable Down-Counting Timer Channel

This block is a single timer channel for a larger peripheral. It counts down from a programmable start value. A prescaler produces count enables from the bus clock. The channel offers three behaviours when the count reaches zero: wrap to all ones (free-running), reload from the load register (periodic), or stop (one-shot). It counts either the low 16 bits or the full 32 bits, and the width can be changed while it runs. In 16-bit width the upper half of the count is kept as it is.

An external bus adapter decodes addresses. It presents a write strobe with a register select and data, and a read select whose data returns one cycle later. Two load registers are written through separate selects. One of them also copies the new value into the count at once. The other only changes the value used at the next reload. A raw interrupt flag is set when the count steps down to zero and is cleared by a write to the clear select. The interrupt output is that flag gated by an enable bit.

Top module: `tmr_channel`

## Requirements
- R1: After reset, the control register reads 0x20 (interrupt enable only), the count reads 0xFFFFFFFF, the load register reads 0, the raw flag reads 0 and `irq` is low.
- R2: Control bits are: bit7 run, bit6 periodic (0 = free-running), bit5 interrupt enable, bits3:2 prescale, bit1 width (1 = 32-bit), bit0 one-shot. Bit 4 and bits 31:8 are dropped on write and read as zero.
- R3: Select codes are 0 load, 1 count, 2 control, 3 interrupt clear (write only), 4 raw flag, 5 masked flag, 6 background load. `rd_data` is registered and shows the selected register one cycle after `rd_sel`. Codes 3 and 7 read as zero.
- R4: In free-running mode, a step taken at zero sets the active width of the count to all ones.
- R5: In periodic mode, a step taken at zero reloads the active width of the count from the load register.
- R6: A write to select 0 stores the full word in the load register and copies its active width into the count on the same edge. This write takes priority over a step in that cycle.
- R7: A write to select 6 stores the load register and leaves the count unchanged. The new value is used at the next reload.
- R8: With width 0, only bits 15:0 of the count change. Bits 31:16 of the count and of the load register are kept and read back unchanged.
- R9: The raw flag is set on the step that takes the active count from 1 to 0. A write to select 3 clears it.
- R10: The masked flag (select 5) and the registered `irq` output equal the raw flag AND the interrupt enable bit.
- R11: In one-shot mode the channel stops after reaching zero. Writing select 0 with a value whose active width is non-zero restarts it.
- R12: Any control write with run set restarts a stopped channel, even if run was already set. At the next step the count reloads (periodic) or wraps (free-running).
- R13: Prescale values 0, 1 and 2 give one step every 1, 16 and 256 clocks, and 3 acts as 2. The prescaler restarts on every control write, so the first step comes that many clocks after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register select for read data |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Masked interrupt, registered |

## Verification
A stopped-state flag left set wrongly appears at the count port as a value that stays frozen. A flag that clears too early appears as an extra reload. In both cases the count differs from the expected value by a known number of steps on the first read after the run is stopped. A wrong prescaler limit or a wrong width mask changes the count after the first or second step, so every test stops the channel at a known edge and reads the count back. A wrong flag or mask path shows on `irq` on the clock right after the write or step that should change it.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

  typedef enum logic [2:0] {
    SEL_LOAD   = 3'd0,
    SEL_COUNT  = 3'd1,
    SEL_CTRL   = 3'd2,
    SEL_CLR    = 3'd3,
    SEL_RAW    = 3'd4,
    SEL_MASKED = 3'd5,
    SEL_BGLOAD = 3'd6,
    SEL_SPARE  = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic       run;
    logic       periodic;
    logic       irq_en;
    logic [1:0] prescale;
    logic       wide;
    logic       single;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{run: 1'b0, periodic: 1'b0, irq_en: 1'b1,
                                   prescale: 2'd0, wide: 1'b0, single: 1'b0};

  function automatic logic [7:0] ctrl_to_bits(input ctrl_t c);
    return {c.run, c.periodic, c.irq_en, 1'b0, c.prescale, c.wide, c.single};
  endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int MID_SHIFT = 4,
  parameter int HI_SHIFT  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] prescale,
  output logic       tick
);
  localparam int PW = HI_SHIFT;
  localparam logic [PW-1:0] MID_LIMIT = PW'((1 << MID_SHIFT) - 1);
  localparam logic [PW-1:0] HI_LIMIT  = '1;

  logic [PW-1:0] pcnt_q;
  logic [PW-1:0] limit;

  always_comb begin
    unique case (prescale)
      2'd0:    limit = '0;
      2'd1:    limit = MID_LIMIT;
      default: limit = HI_LIMIT;   // code 3 behaves as code 2
    endcase
  end

  assign tick = run && (pcnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || restart || !run || tick) pcnt_q <= '0;
    else                                pcnt_q <= pcnt_q + PW'(1);
  end

  AST_PCNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    pcnt_q <= limit) else $error("prescaler count past limit"); // R13

endmodule

// File: rtl/tmr_downcount.sv
module tmr_downcount #(
  parameter int CW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          periodic,
  input  logic          single,
  input  logic          wide,
  input  logic          restart,
  input  logic          load_wr,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] reload_val,
  output logic [CW-1:0] cnt_q,
  output logic          zero_evt
);
  logic [CW-1:0] mask, cur, cnt_d;
  logic          halted_q, halted_d, step;

  assign mask = wide ? '1 : CW'({LW{1'b1}});
  assign cur  = cnt_q & mask;
  assign step = tick && !halted_q;

  always_comb begin
    cnt_d    = cnt_q;
    halted_d = halted_q;
    zero_evt = 1'b0;
    if (restart) halted_d = 1'b0;
    if (load_wr) begin
      cnt_d = (cnt_q & ~mask) | (load_val & mask);
      if ((load_val & mask) != '0) halted_d = 1'b0;
    end else if (step) begin
      if (cur == '0) begin
        cnt_d = (cnt_q & ~mask) | ((periodic ? reload_val : '1) & mask);
      end else begin
        cnt_d = (cnt_q & ~mask) | ((cur - CW'(1)) & mask);
        if (cur == CW'(1)) begin
          zero_evt = 1'b1;
          if (single) halted_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '1;
      halted_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      halted_q <= halted_d;
    end
  end

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (halted_q && !load_wr && !restart) |=> $stable(cnt_q))
    else $error("stopped count moved"); // R11
  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (rst)
    !wide |=> $stable(cnt_q[CW-1:LW]))
    else $error("upper half changed in narrow width"); // R8
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    load_wr |=> ((cnt_q & $past(mask)) == $past(load_val & mask)))
    else $error("load write not copied to count"); // R6

endmodule

// File: rtl/tmr_irqflag.sv
module tmr_irqflag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic irq_en_next,
  output logic raw_q,
  output logic irq_q
);
  logic raw_d;

  assign raw_d = set || (raw_q && !clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      raw_q <= raw_d;
      irq_q <= raw_d && irq_en_next;
    end
  end

  AST_CLR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !raw_q) else $error("clear ignored"); // R9

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int CNT_W     = 32,
  parameter int NARROW_W  = 16,
  parameter int MID_SHIFT = 4,
  parameter int HI_SHIFT  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq
);
  import tmr_chan_pkg::*;

  ctrl_t            ctrl_q, ctrl_d, ctrl_wdata;
  logic [CNT_W-1:0] load_q, cnt_q;
  logic             ctrl_wr, load_wr, bg_wr, clr_wr, restart;
  logic             tick, zero_evt, raw_q, irq_q;

  assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
  assign load_wr = wr_en && (wr_sel == SEL_LOAD);
  assign bg_wr   = wr_en && (wr_sel == SEL_BGLOAD);
  assign clr_wr  = wr_en && (wr_sel == SEL_CLR);

  assign ctrl_wdata = '{run: wr_data[7], periodic: wr_data[6], irq_en: wr_data[5],
                        prescale: wr_data[3:2], wide: wr_data[1], single: wr_data[0]};
  assign ctrl_d  = ctrl_wr ? ctrl_wdata : ctrl_q;
  assign restart = ctrl_wr && ctrl_wdata.run;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RESET;
      load_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (load_wr || bg_wr) load_q <= wr_data;
    end
  end

  tmr_prescale #(.MID_SHIFT(MID_SHIFT), .HI_SHIFT(HI_SHIFT)) u_pre (
    .clk(clk), .rst(rst), .run(ctrl_q.run), .restart(ctrl_wr),
    .prescale(ctrl_q.prescale), .tick(tick)
  );

  tmr_downcount #(.CW(CNT_W), .LW(NARROW_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .periodic(ctrl_q.periodic),
    .single(ctrl_q.single), .wide(ctrl_q.wide), .restart(restart),
    .load_wr(load_wr), .load_val(wr_data), .reload_val(load_q),
    .cnt_q(cnt_q), .zero_evt(zero_evt)
  );

  tmr_irqflag u_irq (
    .clk(clk), .rst(rst), .set(zero_evt), .clr(clr_wr),
    .irq_en_next(ctrl_d.irq_en), .raw_q(raw_q), .irq_q(irq_q)
  );

  assign irq = irq_q;

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_sel)
        SEL_LOAD, SEL_BGLOAD: rd_data <= load_q;
        SEL_COUNT:            rd_data <= cnt_q;
        SEL_CTRL:             rd_data <= CNT_W'(ctrl_to_bits(ctrl_q));
        SEL_RAW:              rd_data <= CNT_W'(raw_q);
        SEL_MASKED:           rd_data <= CNT_W'(raw_q && ctrl_q.irq_en);
        default:              rd_data <= '0;
      endcase
    end
  end

  AST_ZERO_SETS_RAW: assert property (@(posedge clk) disable iff (rst)
    zero_evt |=> raw_q) else $error("zero step did not set flag"); // R9
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ctrl_q.irq_en) else $error("irq without enable"); // R10

endmodule

// File: tb/test_tmr_channel.sv
module test_tmr_channel;
  localparam logic [2:0] S_LOAD = 3'd0, S_CNT = 3'd1, S_CTRL = 3'd2, S_CLR = 3'd3,
                         S_RAW = 3'd4, S_MSK = 3'd5, S_BG = 3'd6, S_SPARE = 3'd7;

  logic        clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [2:0]  wr_sel = '0, rd_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;

  always #10 clk = ~clk;   // 50 MHz

  tmr_channel i_tmr_channel (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
  );

  int          n_chk = 0, n_err = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_vld = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver tasks: called at a falling edge, return at a falling edge
  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, input logic [31:0] e, input string tag);
    rd_sel = s; exp_q.push_back(e); tag_q.push_back(tag); rd_vld = 1'b1;
    @(negedge clk);
    rd_vld = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    check(tag, {31'b0, irq}, {31'b0, e});
  endtask

  // monitor: pops one expected item per read and compares after the capture edge
  always begin
    @(posedge clk);
    if (rd_vld) begin
      #2;
      check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  initial begin
    #(200000 * 20);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1 reset state
    rd(S_CTRL, 32'h20, "R1 control");
    rd(S_CNT, 32'hFFFF_FFFF, "R1 count");
    rd(S_LOAD, 32'h0, "R1 load");
    rd(S_RAW, 32'h0, "R1 raw");
    chk_irq(1'b0, "R1 irq");
    // R3 unused selects
    rd(S_SPARE, 32'h0, "R3 spare select");
    rd(S_CLR, 32'h0, "R3 clear select");
    // R2 field masking
    wr(S_CTRL, 32'hFFFF_FF10);
    rd(S_CTRL, 32'h0, "R2 dropped bits");
    wr(S_CTRL, 32'h2D);
    rd(S_CTRL, 32'h2D, "R2 fields");
    wr(S_CTRL, 32'h20);
    // R6 / R8 narrow load
    wr(S_LOAD, 32'h1234_0005);
    rd(S_LOAD, 32'h1234_0005, "R6 load kept whole");
    rd(S_CNT, 32'hFFFF_0005, "R8 upper count held");
    // R4 narrow free-running wrap: 7 steps from 5
    wr(S_CTRL, 32'hA0); idle(6); wr(S_CTRL, 32'h20);
    rd(S_CNT, 32'hFFFF_FFFE, "R4 narrow wrap");
    rd(S_RAW, 32'h1, "R9 raw set");
    rd(S_MSK, 32'h1, "R10 masked");
    chk_irq(1'b1, "R10 irq high");
    wr(S_CLR, 32'h0);
    rd(S_RAW, 32'h0, "R9 raw cleared");
    chk_irq(1'b0, "R9 irq cleared");
    // R5 periodic, mask off: 5 steps from 3
    wr(S_CTRL, 32'h42); wr(S_LOAD, 32'h3);
    rd(S_CNT, 32'h3, "R6 wide load");
    wr(S_CTRL, 32'hC2); idle(4); wr(S_CTRL, 32'h42);
    rd(S_CNT, 32'h2, "R5 periodic reload");
    rd(S_RAW, 32'h1, "R9 raw periodic");
    rd(S_MSK, 32'h0, "R10 masked off");
    chk_irq(1'b0, "R10 irq masked");
    wr(S_CTRL, 32'h62);
    chk_irq(1'b1, "R10 irq after enable");
    wr(S_CLR, 32'h0); wr(S_CTRL, 32'h42);
    // R7 background load
    wr(S_BG, 32'h10);
    rd(S_CNT, 32'h2, "R7 count kept");
    rd(S_LOAD, 32'h10, "R7 load updated");
    wr(S_CTRL, 32'hC2); idle(3); wr(S_CTRL, 32'h42);
    rd(S_CNT, 32'hF, "R7 new reload used");
    // R11 one-shot stop
    wr(S_CLR, 32'h0); wr(S_CTRL, 32'h43); wr(S_LOAD, 32'h2);
    wr(S_CTRL, 32'hC3); idle(8); wr(S_CTRL, 32'h43);
    rd(S_CNT, 32'h0, "R11 stopped at zero");
    rd(S_RAW, 32'h1, "R11 raw on expiry");
    // R12 resume after mode change
    wr(S_CLR, 32'h0);
    wr(S_CTRL, 32'hC2); idle(3); wr(S_CTRL, 32'h42);
    rd(S_CNT, 32'h2, "R12 resume periodic");
    // R12 rewrite with run already set
    wr(S_CTRL, 32'hC3); idle(4); wr(S_CTRL, 32'hC3); idle(1); wr(S_CTRL, 32'h43);
    rd(S_CNT, 32'h1, "R12 run rewrite restarts");
    // R11 restart by load write
    wr(S_CTRL, 32'hC3); idle(3); wr(S_LOAD, 32'h5); idle(1); wr(S_CTRL, 32'h43);
    rd(S_CNT, 32'h3, "R11 load restarts");
    // R13 prescale
    wr(S_CLR, 32'h0); wr(S_CTRL, 32'h42); wr(S_LOAD, 32'h100);
    wr(S_CTRL, 32'hC6); idle(39); wr(S_CTRL, 32'h42);
    rd(S_CNT, 32'hFE, "R13 divide by 16");
    wr(S_LOAD, 32'h100);
    wr(S_CTRL, 32'hCE); idle(599); wr(S_CTRL, 32'h4E);
    rd(S_CNT, 32'hFE, "R13 code 3 as 256");
    rd(S_CTRL, 32'h4E, "R2 prescale field");
    // R8 / R5 narrow periodic keeps upper half across width change
    wr(S_CTRL, 32'h42); wr(S_LOAD, 32'hABCD_0002);
    rd(S_CNT, 32'hABCD_0002, "R6 wide load full");
    wr(S_CTRL, 32'h40); wr(S_CTRL, 32'hC0); idle(3); wr(S_CTRL, 32'h42);
    rd(S_CNT, 32'hABCD_0001, "R8 narrow reload upper held");
    // R4 wide free-running wrap
    wr(S_CLR, 32'h0); wr(S_CTRL, 32'h02); wr(S_LOAD, 32'h1);
    wr(S_CTRL, 32'h82); idle(2); wr(S_CTRL, 32'h02);
    rd(S_CNT, 32'hFFFF_FFFE, "R4 wide wrap");
    idle(2);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule